// File: doc/BRIEF.md
# Cascaded Two-Level Priority Interrupt Controller

This block gathers sixteen interrupt sources into a single processor interrupt request. It is built from two identical eight-input priority cores. The primary core serves channels 0 to 7. The secondary core serves channels 8 to 15. The secondary core's request output is wired to input 2 of the primary core, so channel 2 carries the cascade and is not an external line.

Two inputs come from inside the chip rather than from pins. Channel 0 follows the system timer output. Channel 13 follows an active-low floating-point error flag.

Software programs each core through its own pair of byte-wide I/O addresses. A core does nothing useful until it has received a four-word initialization sequence. After that, the same addresses accept mask writes, end-of-interrupt commands and a read-select command. A separate pair of I/O addresses holds the per-channel trigger-mode bits.

The processor answers `intr_o` with a one-cycle acknowledge pulse. In the following cycle the block presents the interrupt vector. When the primary core's winning input is the cascade input, the secondary core supplies the vector.

Top module: `pic_cascade_top`

## Requirements
- R1: After reset, `intr_o` and `vec_valid_o` are 0. Both mask registers read back 0xFF. No interrupt is raised until the primary core has completed initialization, even if external lines toggle.
- R2: A command write with address bit 0 = 0 and data bit 4 = 1 starts initialization. This write clears that core's mask, in-service and request registers. The next three writes with address bit 0 = 1 are, in order: the vector base (data bits 7:3), the cascade word (accepted, no effect) and the mode word. The core is operational only after the third of these writes. A new start write in the middle of the sequence restarts it.
- R3: In operation, a write with address bit 0 = 1 loads the mask register. A masked channel raises no interrupt. The mask reads back at address bit 0 = 1.
- R4: A channel in edge mode latches a request on a 0-to-1 transition. The request stays pending after the line falls, until it is acknowledged.
- R5: The trigger registers sit at 0x4D0 (primary) and 0x4D1 (secondary) and read back. A 1 in a bit makes that channel level-sensitive: its request follows the line, and it is withdrawn when the line falls.
- R6: Priority is fixed, with the lowest channel index winning. A pending unmasked request raises `intr_o` only if its index is lower than every set in-service bit of its core.
- R7: One cycle after an `inta_i` pulse, `vec_valid_o` is 1 for exactly that cycle. At the same time `vec_o` = {vector base[7:3], 3-bit winning index}. The acknowledge sets the in-service bit and clears the request bit of the winner.
- R8: A request on the secondary core reaches primary input 2. Its acknowledge returns the secondary core's vector and sets in-service bit 2 of the primary core as well as the secondary core's own bit.
- R9: A command write of 0x20 (address bit 0 = 0, data bits 7:5 = 001, bit 4 = 0, bit 3 = 0) clears the lowest-index set in-service bit of that core.
- R10: Channel 0 follows `timer_i`, and channel 13 follows the inverted `fpu_err_n_i`. External bits 0, 2 and 13 of `irq_i` have no effect.
- R11: An acknowledge with no eligible request returns index 7 with the primary base and leaves every in-service register unchanged.
- R12: Mode word bit 1 = 1 selects automatic end-of-interrupt. In that mode an acknowledge does not set the in-service bit.
- R13: A command write with address bit 0 = 0, bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects what address bit 0 = 0 reads: the request register when bit 0 = 0, the in-service register when bit 0 = 1. The start write selects the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | External interrupt lines (bits 0, 2, 13 unused) |
| timer_i | input | 1 | Timer output, drives channel 0 |
| fpu_err_n_i | input | 1 | Active-low floating-point error, drives channel 13 |
| io_wr_i | input | 1 | I/O write strobe, one cycle |
| io_rd_i | input | 1 | I/O read enable |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, combinational, 0 when not reading |
| inta_i | input | 1 | Interrupt acknowledge pulse |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt vector |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
The assertions rely on `inta_i` being a pulse. They also rely on end-of-interrupt commands never arriving in the same cycle as an acknowledge, and on the mode word giving the secondary core automatic end-of-interrupt only if software expects it. The stimulus issues at most one bus operation or one acknowledge per cycle, which keeps every command apart from every acknowledge. Software is modelled as initializing each core fully before the random phase. Random traffic only toggles lines, acknowledges, masks and sends end-of-interrupt commands, so the in-service registers change only through acknowledges and those commands.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int CH   = 8;
    localparam int IDXW = $clog2(CH);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W2,
        ST_W3,
        ST_W4,
        ST_RUN
    } init_st_e;

    typedef struct packed {
        init_st_e        st;
        logic [4:0]      base;
        logic            aeoi;
        logic            rd_isr;
        logic [CH-1:0]   irr;
        logic [CH-1:0]   isr;
        logic [CH-1:0]   imr;
        logic [CH-1:0]   prev;
        logic [CH-1:0]   lvl;
    } core_state_t;

    typedef struct packed {
        logic [7:0] vec;
        logic       valid;
    } ack_state_t;

    localparam logic [2:0] EOI_NONSPEC = 3'b001;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH-1:0]   irq_in,
    input  logic            cmd_wr,
    input  logic            cmd_a0,
    input  logic [7:0]      cmd_data,
    input  logic            trig_wr,
    input  logic            ack,
    output logic            int_o,
    output logic [IDXW-1:0] win_idx,
    output logic [7:0]      vec_o,
    output logic [7:0]      rd_o,
    output logic [CH-1:0]   lvl_o,
    output logic [CH-1:0]   isr_o,
    output logic            run_o
);
    core_state_t st_q, st_d;

    logic            req_found, svc_found;
    logic [IDXW-1:0] req_idx, svc_idx;
    logic            win_ok;

    pic_prio #(.W(CH)) u_req (
        .req   (st_q.irr & ~st_q.imr),
        .found (req_found),
        .idx   (req_idx)
    );

    pic_prio #(.W(CH)) u_svc (
        .req   (st_q.isr),
        .found (svc_found),
        .idx   (svc_idx)
    );

    assign win_ok  = (st_q.st == ST_RUN) && req_found && (!svc_found || (req_idx < svc_idx));
    assign int_o   = win_ok;
    assign win_idx = req_idx;
    assign vec_o   = {st_q.base, win_ok ? req_idx : IDXW'(CH - 1)};
    assign rd_o    = cmd_a0 ? st_q.imr : (st_q.rd_isr ? st_q.isr : st_q.irr);
    assign lvl_o   = st_q.lvl;
    assign isr_o   = st_q.isr;
    assign run_o   = (st_q.st == ST_RUN);

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        for (int i = 0; i < CH; i++) begin
            st_d.irr[i] = st_q.lvl[i] ? irq_in[i]
                                      : (st_q.irr[i] | (irq_in[i] & ~st_q.prev[i]));
        end
        if (ack && win_ok) begin
            st_d.irr[req_idx] = 1'b0;
            if (!st_q.aeoi) begin
                st_d.isr[req_idx] = 1'b1;
            end
        end
        if (trig_wr) begin
            st_d.lvl = cmd_data;
        end
        if (cmd_wr) begin
            if (!cmd_a0 && cmd_data[4]) begin
                st_d.st     = ST_W2;
                st_d.isr    = '0;
                st_d.irr    = '0;
                st_d.imr    = '0;
                st_d.aeoi   = 1'b0;
                st_d.rd_isr = 1'b0;
            end else if (cmd_a0) begin
                case (st_q.st)
                    ST_W2: begin
                        st_d.base = cmd_data[7:3];
                        st_d.st   = ST_W3;
                    end
                    ST_W3: st_d.st = ST_W4;
                    ST_W4: begin
                        st_d.aeoi = cmd_data[1];
                        st_d.st   = ST_RUN;
                    end
                    ST_RUN: st_d.imr = cmd_data;
                    default: ;
                endcase
            end else if (st_q.st == ST_RUN) begin
                if (!cmd_data[3]) begin
                    if ((cmd_data[7:5] == EOI_NONSPEC) && svc_found) begin
                        st_d.isr[svc_idx] = 1'b0;
                    end
                end else if (cmd_data[1]) begin
                    st_d.rd_isr = cmd_data[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= ST_IDLE;
            st_q.imr  <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
    import pic_pkg::*;
#(
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   MST_BASE   = 16'h0020,
    parameter logic [AW-1:0]   SLV_BASE   = 16'h00A0,
    parameter logic [AW-1:0]   TRIG_BASE  = 16'h04D0,
    parameter int              CASCADE_IN = 2,
    parameter int              TIMER_IN   = 0,
    parameter int              FPU_IN     = 5,
    localparam int             NCORE      = 2,
    localparam int             NIRQ       = NCORE * CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            timer_i,
    input  logic            fpu_err_n_i,
    input  logic            io_wr_i,
    input  logic            io_rd_i,
    input  logic [AW-1:0]   io_addr_i,
    input  logic [7:0]      io_wdata_i,
    output logic [7:0]      io_rdata_o,
    input  logic            inta_i,
    output logic            intr_o,
    output logic [7:0]      vec_o,
    output logic            vec_valid_o
);
    logic [CH-1:0]   core_in  [NCORE];
    logic            int_w    [NCORE];
    logic [IDXW-1:0] win_w    [NCORE];
    logic [7:0]      vec_w    [NCORE];
    logic [7:0]      rd_w     [NCORE];
    logic [CH-1:0]   lvl_w    [NCORE];
    logic [CH-1:0]   isr_w    [NCORE];
    logic            run_w    [NCORE];
    logic            sel_cmd  [NCORE];
    logic            sel_trig [NCORE];
    logic            ack_w    [NCORE];
    logic            cas_win;
    logic            unused_ext;

    ack_state_t ak_q, ak_d;

    assign cas_win = int_w[0] && (win_w[0] == IDXW'(CASCADE_IN));

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        localparam logic [AW-1:0] CMD_ADDR  = (g == 0) ? MST_BASE : SLV_BASE;
        localparam logic [AW-1:0] TRIG_ADDR = TRIG_BASE + AW'(g);

        for (genvar b = 0; b < CH; b++) begin : g_src
            if (g == 0 && b == TIMER_IN) begin : g_tmr
                assign core_in[g][b] = timer_i;
            end else if (g == 0 && b == CASCADE_IN) begin : g_cas
                assign core_in[g][b] = int_w[1];
            end else if (g == 1 && b == FPU_IN) begin : g_fpu
                assign core_in[g][b] = ~fpu_err_n_i;
            end else begin : g_ext
                assign core_in[g][b] = irq_i[g*CH+b];
            end
        end

        assign sel_cmd[g]  = (io_addr_i[AW-1:1] == CMD_ADDR[AW-1:1]);
        assign sel_trig[g] = (io_addr_i == TRIG_ADDR);

        if (g == 0) begin : g_ack_m
            assign ack_w[g] = inta_i;
        end else begin : g_ack_s
            assign ack_w[g] = inta_i && cas_win;
        end

        pic_core u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (core_in[g]),
            .cmd_wr   (io_wr_i && sel_cmd[g]),
            .cmd_a0   (io_addr_i[0]),
            .cmd_data (io_wdata_i),
            .trig_wr  (io_wr_i && sel_trig[g]),
            .ack      (ack_w[g]),
            .int_o    (int_w[g]),
            .win_idx  (win_w[g]),
            .vec_o    (vec_w[g]),
            .rd_o     (rd_w[g]),
            .lvl_o    (lvl_w[g]),
            .isr_o    (isr_w[g]),
            .run_o    (run_w[g])
        );
    end

    assign unused_ext = ^{irq_i[TIMER_IN], irq_i[CASCADE_IN], irq_i[CH+FPU_IN]};

    always_comb begin
        io_rdata_o = '0;
        if (io_rd_i) begin
            for (int g = 0; g < NCORE; g++) begin
                if (sel_cmd[g])  io_rdata_o = rd_w[g];
                if (sel_trig[g]) io_rdata_o = lvl_w[g];
            end
        end
    end

    always_comb begin
        ak_d       = ak_q;
        ak_d.valid = inta_i;
        if (inta_i) begin
            ak_d.vec = cas_win ? vec_w[1] : vec_w[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ak_q <= '0;
        else        ak_q <= ak_d;
    end

    assign intr_o      = int_w[0];
    assign vec_o       = ak_q.vec;
    assign vec_valid_o = ak_q.valid;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inta,
    input logic       intr,
    input logic       vec_valid,
    input logic [7:0] m_isr,
    input logic [7:0] s_isr,
    input logic       m_run,
    input logic       s_run
);
    logic [7:0] m_isr_q, s_isr_q, m_new, s_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_isr_q <= '0;
            s_isr_q <= '0;
        end else begin
            m_isr_q <= m_isr;
            s_isr_q <= s_isr;
        end
    end

    assign m_new = m_isr & ~m_isr_q;
    assign s_new = s_isr & ~s_isr_q;

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) inta |=> vec_valid); // R7
    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |-> $past(inta)); // R7
    AST_ISR_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(m_new) <= 1); // R7
    AST_ISR_SET_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n) (|m_new) |-> $past(inta)); // R7
    AST_ISR_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_new) |-> ((m_isr_q == 8'h00) || (m_new < (m_isr_q & (~m_isr_q + 8'd1))))); // R6
    AST_QUIET_UNTIL_INIT: assert property (@(posedge clk) disable iff (!rst_n) !m_run |-> !intr); // R1
    AST_SLV_ISR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n) (|s_new) |-> $past(inta)); // R8
    AST_SLV_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !s_run |-> (s_isr == 8'h00)); // R2
endmodule

bind pic_cascade_top pic_cascade_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta      (inta_i),
    .intr      (intr_o),
    .vec_valid (vec_valid_o),
    .m_isr     (isr_w[0]),
    .s_isr     (isr_w[1]),
    .m_run     (run_w[0]),
    .s_run     (run_w[1])
);

// File: tb/pic_cascade_top_tb_top.sv
module pic_cascade_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        timer = 1'b0, fpu_n = 1'b1;
    logic        io_wr = 1'b0, io_rd = 1'b0, inta = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata, vec;
    logic        intr, vec_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cascade_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .timer_i(timer), .fpu_err_n_i(fpu_n),
        .io_wr_i(io_wr), .io_rd_i(io_rd), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
        .io_rdata_o(io_rdata), .inta_i(inta), .intr_o(intr), .vec_o(vec), .vec_valid_o(vec_valid)
    );

    int n_chk = 0, n_fail = 0;

    logic [7:0] m_irr [2], m_isr [2], m_imr [2], m_prev [2], m_lvl [2];
    logic [4:0] m_base [2];
    int         m_st [2];
    logic       m_aeoi [2], m_rsel [2];
    logic [7:0] e_vec = '0;
    logic       e_vv = 1'b0;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int win(input int c);
        int req_i, svc_i;
        logic [7:0] pend;
        pend  = m_irr[c] & ~m_imr[c];
        req_i = 8;
        svc_i = 8;
        for (int i = 7; i >= 0; i--) begin
            if (pend[i]) req_i = i;
            if (m_isr[c][i]) svc_i = i;
        end
        if (m_st[c] != 4 || req_i == 8 || req_i >= svc_i) return 8;
        return req_i;
    endfunction

    task automatic core_step(input int c, input logic [7:0] in, input logic wr, input logic a0,
                             input logic [7:0] d, input logic tw, input logic ack, input int w);
        logic [7:0] nirr, nisr;
        int svc;
        svc = 8;
        for (int i = 7; i >= 0; i--) if (m_isr[c][i]) svc = i;
        for (int i = 0; i < 8; i++)
            nirr[i] = m_lvl[c][i] ? in[i] : (m_irr[c][i] | (in[i] & ~m_prev[c][i]));
        nisr = m_isr[c];
        if (ack && w != 8) begin
            nirr[w] = 1'b0;
            if (!m_aeoi[c]) nisr[w] = 1'b1;
        end
        m_prev[c] = in;
        if (tw) m_lvl[c] = d;
        if (wr) begin
            if (!a0 && d[4]) begin
                m_st[c] = 1; nisr = '0; nirr = '0; m_imr[c] = '0; m_aeoi[c] = 1'b0; m_rsel[c] = 1'b0;
            end else if (a0) begin
                case (m_st[c])
                    1: begin m_base[c] = d[7:3]; m_st[c] = 2; end
                    2: m_st[c] = 3;
                    3: begin m_aeoi[c] = d[1]; m_st[c] = 4; end
                    4: m_imr[c] = d;
                    default: ;
                endcase
            end else if (m_st[c] == 4) begin
                if (!d[3]) begin
                    if (d[7:5] == 3'b001 && svc != 8) nisr[svc] = 1'b0;
                end else if (d[1]) m_rsel[c] = d[0];
            end
        end
        m_irr[c] = nirr;
        m_isr[c] = nisr;
    endtask

    // advance one clock; the model and the DUT see the same inputs
    task automatic cycle();
        int w0, w1;
        logic s_int;
        logic [7:0] si, mi, nvec;
        w1    = win(1);
        s_int = (w1 != 8);
        w0    = win(0);
        si    = {irq[15:14], ~fpu_n, irq[12:8]};
        mi    = {irq[7:3], s_int, irq[1], timer};
        nvec  = e_vec;
        if (inta) begin
            if (w0 == 8)      nvec = {m_base[0], 3'd7};
            else if (w0 == 2) nvec = {m_base[1], (w1 == 8) ? 3'd7 : 3'(w1)};
            else              nvec = {m_base[0], 3'(w0)};
        end
        core_step(0, mi, io_wr && io_addr[15:1] == 15'h0010, io_addr[0], io_wdata,
                  io_wr && io_addr == 16'h04D0, inta, w0);
        core_step(1, si, io_wr && io_addr[15:1] == 15'h0050, io_addr[0], io_wdata,
                  io_wr && io_addr == 16'h04D1, inta && w0 == 2, w1);
        e_vv  = inta;
        e_vec = nvec;
        @(posedge clk);
        @(negedge clk);
        chk("R7 vector valid", vec_valid, e_vv);
        if (e_vv) chk("R7 vector", vec, e_vec);
        chk("R6 intr", intr, win(0) != 8);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        cycle();
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        io_rd = 1'b1; io_addr = a;
        #1;
        chk(req, io_rdata, exp);
        io_rd = 1'b0;
    endtask

    task automatic ack_chk(input string req, input logic [7:0] exp);
        inta = 1'b1;
        cycle();
        inta = 1'b0;
        chk(req, vec, exp);
    endtask

    task automatic pulse(input int b);
        irq[b] = 1'b1;
        cycle();
        irq[b] = 1'b0;
    endtask

    task automatic init_core(input logic [15:0] a, input logic [7:0] base, input logic [7:0] mode);
        wr(a, 8'h11);
        wr(a + 16'd1, base);
        wr(a + 16'd1, (a == 16'h0020) ? 8'h04 : 8'h02);
        wr(a + 16'd1, mode);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int c = 0; c < 2; c++) begin
            m_irr[c] = '0; m_isr[c] = '0; m_imr[c] = '1; m_prev[c] = '0; m_lvl[c] = '0;
            m_base[c] = '0; m_st[c] = 0; m_aeoi[c] = 1'b0; m_rsel[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 intr at reset", intr, 1'b0);
        chk("R1 vec_valid at reset", vec_valid, 1'b0);
        rst_n = 1'b1;
        rd_chk("R1 master mask reset", 16'h0021, 8'hFF);
        rd_chk("R1 slave mask reset", 16'h00A1, 8'hFF);
        irq[3] = 1'b1;
        idle(2);
        chk("R1 no intr before init", intr, 1'b0);
        irq[3] = 1'b0;
        idle(1);

        init_core(16'h0020, 8'h08, 8'h01);
        init_core(16'h00A0, 8'h70, 8'h01);
        rd_chk("R2 mask cleared by init", 16'h0021, 8'h00);
        chk("R2 no stale request", intr, 1'b0);

        pulse(5);
        idle(1);
        chk("R4 edge held after fall", intr, 1'b1);
        ack_chk("R7 vector ch5", 8'h0D);
        chk("R7 intr drops after ack", intr, 1'b0);
        rd_chk("R13 default reads request reg", 16'h0020, 8'h00);
        wr(16'h0020, 8'h0B);
        rd_chk("R13 in-service read", 16'h0020, 8'h20);
        wr(16'h0020, 8'h20);
        rd_chk("R9 eoi clears in-service", 16'h0020, 8'h00);

        irq[6] = 1'b1; irq[4] = 1'b1;
        cycle();
        irq[6] = 1'b0; irq[4] = 1'b0;
        idle(1);
        ack_chk("R6 lowest index wins", 8'h0C);
        chk("R6 lower priority blocked by in-service", intr, 1'b0);
        wr(16'h0020, 8'h20);
        chk("R9 eoi releases pending", intr, 1'b1);
        ack_chk("R6 second request", 8'h0E);
        wr(16'h0020, 8'h20);

        wr(16'h0021, 8'h08);
        pulse(3);
        idle(1);
        chk("R3 masked channel silent", intr, 1'b0);
        rd_chk("R3 mask readback", 16'h0021, 8'h08);
        wr(16'h0021, 8'h00);
        chk("R3 unmask releases", intr, 1'b1);
        ack_chk("R3 vector ch3", 8'h0B);
        wr(16'h0020, 8'h20);

        pulse(10);
        idle(2);
        chk("R8 cascade raises intr", intr, 1'b1);
        ack_chk("R8 slave vector", 8'h72);
        wr(16'h00A0, 8'h0B);
        rd_chk("R8 master in-service bit2", 16'h0020, 8'h04);
        rd_chk("R8 slave in-service", 16'h00A0, 8'h04);
        wr(16'h00A0, 8'h20);
        wr(16'h0020, 8'h20);

        irq[0] = 1'b1; irq[2] = 1'b1; irq[13] = 1'b1;
        idle(3);
        chk("R10 replaced external lines ignored", intr, 1'b0);
        irq[0] = 1'b0; irq[2] = 1'b0; irq[13] = 1'b0;
        timer = 1'b1;
        idle(1);
        ack_chk("R10 timer on ch0", 8'h08);
        timer = 1'b0;
        wr(16'h0020, 8'h20);
        fpu_n = 1'b0;
        idle(2);
        ack_chk("R10 fpu error on ch13", 8'h75);
        fpu_n = 1'b1;
        wr(16'h00A0, 8'h20);
        wr(16'h0020, 8'h20);

        chk("R11 nothing pending", intr, 1'b0);
        ack_chk("R11 spurious vector", 8'h0F);
        rd_chk("R11 in-service untouched", 16'h0020, 8'h00);

        wr(16'h04D0, 8'h80);
        rd_chk("R5 trigger readback", 16'h04D0, 8'h80);
        irq[7] = 1'b1;
        idle(1);
        chk("R5 level asserts", intr, 1'b1);
        irq[7] = 1'b0;
        idle(1);
        chk("R5 level withdrawn", intr, 1'b0);

        wr(16'h0020, 8'h11);
        wr(16'h0021, 8'h40);
        wr(16'h0020, 8'h11);
        init_core(16'h0020, 8'h08, 8'h03);
        pulse(4);
        idle(1);
        ack_chk("R12 auto-eoi vector", 8'h0C);
        chk("R2 restart keeps second base", {27'd0, vec[7:3]}, 32'h01);
        wr(16'h0020, 8'h0B);
        rd_chk("R12 no in-service set", 16'h0020, 8'h00);

        init_core(16'h0020, 8'h08, 8'h01);
        wr(16'h04D1, 8'h0C);
        for (int n = 0; n < 4000; n++) begin
            int op;
            if ($urandom % 8 == 0) irq[$urandom % 16] ^= 1'b1;
            if ($urandom % 32 == 0) timer ^= 1'b1;
            if ($urandom % 64 == 0) fpu_n ^= 1'b1;
            op = $urandom % 16;
            if (op < 3 && intr) inta = 1'b1;
            else if (op == 3) inta = 1'b1;
            else if (op == 4) begin io_wr = 1'b1; io_addr = 16'h0020; io_wdata = 8'h20; end
            else if (op == 5) begin io_wr = 1'b1; io_addr = 16'h00A0; io_wdata = 8'h20; end
            else if (op == 6 && $urandom % 8 == 0) begin
                io_wr = 1'b1; io_addr = 16'h0021; io_wdata = 8'($urandom & $urandom);
            end else if (op == 7 && $urandom % 8 == 0) begin
                io_wr = 1'b1; io_addr = 16'h00A1; io_wdata = 8'($urandom & $urandom);
            end
            cycle();
            inta = 1'b0;
            io_wr = 1'b0;
        end
        rd_chk("R3 final master mask", 16'h0021, m_imr[0]);
        rd_chk("R13 final master read", 16'h0020, m_rsel[0] ? m_isr[0] : m_irr[0]);

        report();
        $finish;
    end
endmodule